// File: doc/BRIEF.md
# Floating-Point Coefficient to Hexadecimal Digit Converter

This block turns the real-valued outputs of an unnormalised inverse transform into the exact radix-16 digits of a large integer product. It accepts one floating-point coefficient per digit position, least significant position first. Each coefficient still carries the transform gain 2^k. The block removes that gain by lowering the exponent by k, rounds the result to the nearest integer, and adds the carry left by the position below. It then emits the low hexadecimal digit and keeps the rest as the carry for the position above.

A start flag on the first coefficient of each number clears the running carry. Idle cycles between coefficients are allowed. The running carry is visible at all times, so after the last position it gives the final carry. The caller sends only the real part of each coefficient.

The input word is 35 bits. Bit 34 is the sign. Bits 33:27 hold a 7-bit exponent with bias 63, and bits 26:0 hold a 27-bit fraction with a hidden leading one. An exponent field of 0 encodes zero.

Top module: `scl_digit_emit`

## Requirements
- R1: While reset is asserted and after it is released, `digit_valid` is low and `carry_out` is 0 until the first coefficient reaches the output.
- R2: Each coefficient accepted with `in_valid` high produces exactly one digit, with `digit_valid` high 12 clock cycles later (2 for scaling, 10 for rounding and carry). Digits leave in the order their coefficients arrived.
- R3: A coefficient is divided by 2^`k_shift` by subtracting `k_shift` from its exponent field. An exponent field of 0 is zero. If the subtraction gives a field of 0 or less, the value is treated as zero.
- R4: The scaled value is rounded to the nearest integer, with an exact half rounding away from zero. Results above the integer range saturate.
- R5: Let the sum be the rounded value plus the carry in. `digit` is the sum modulo 16, and `carry_out` becomes the sum divided by 16, rounded down.
- R6: A coefficient flagged with `in_sop` uses a carry in of 0, whatever carry earlier numbers left.
- R7: A coefficient whose sign bit is 1 adds 0 in place of its value. The carry in still passes through to the digit and the next carry.
- R8: Cycles without `in_valid` leave `carry_out` unchanged, so it keeps the final carry of the last digit.
- R9: Integer convolution coefficients of two operands, each disturbed by less than 0.5 and multiplied by 2^k, yield the hexadecimal digits of the exact product, with a final carry of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Coefficient present on `in_val` this cycle |
| in_sop | input | 1 | First (least significant) coefficient of a number |
| in_val | input | 35 | Floating-point coefficient: sign, biased exponent, fraction |
| k_shift | input | 4 | Base-2 log of the transform length, used as the divisor exponent |
| digit_valid | output | 1 | `digit` carries a result this cycle |
| digit | output | 4 | Radix-16 result digit |
| carry_out | output | 21 | Running carry into the next higher digit |

## Verification
The bound checker checks on every cycle that a digit appears exactly 12 cycles after each accepted coefficient. It also checks that the carry stays still whenever no digit is emitted. Two further checks look at a number that starts with a zero or negative coefficient: its first digit and carry must both be zero. The scaling, the rounding near the half-way points, the split of each sum into digit and carry, and the assembly of complete product digits from disturbed convolution coefficients all depend on numeric values. Only the bench scenarios show these, by comparing against digits the bench computes from an independent 64-bit product.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int EXP_W  = 7;
  localparam int FRAC_W = 27;
  localparam int FP_W   = 1 + EXP_W + FRAC_W;
  localparam int MANT_W = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int DIG_W  = 4;

  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] frac;
  } fp_t;
endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/scl_pipe_dly.sv
module scl_pipe_dly #(
  parameter int W = 8,
  parameter int D = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  output logic [W-1:0] out_dat
);
  generate
    if (D == 0) begin : g_wire
      assign out_vld = in_vld;
      assign out_dat = in_dat;
    end else begin : g_regs
      logic         vld_q [D];
      logic [W-1:0] dat_q [D];
      for (genvar s = 0; s < D; s++) begin : g_stage
        logic         vld_d;
        logic [W-1:0] dat_d;
        if (s == 0) begin : g_first
          assign vld_d = in_vld;
          assign dat_d = in_dat;
        end else begin : g_next
          assign vld_d = vld_q[s-1];
          assign dat_d = dat_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) vld_q[s] <= 1'b0;
          else        vld_q[s] <= vld_d;
        end
        always_ff @(posedge clk) begin
          if (vld_d) dat_q[s] <= dat_d;
        end
      end
      assign out_vld = vld_q[D-1];
      assign out_dat = dat_q[D-1];
    end
  endgenerate
endmodule

// File: rtl/scl_exp_scaler.sv
module scl_exp_scaler
  import scl_pkg::*;
#(
  parameter int K_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic           in_sop,
  input  fp_t            in_fp,
  input  logic [K_W-1:0] k_shift,
  output logic           out_vld,
  output logic           out_sop,
  output fp_t            out_fp
);
  localparam int DW = EXP_W + 2;

  // stage 1: exponent difference
  logic              s1_vld_q, s1_sop_q, s1_sgn_q, s1_zero_q;
  logic [FRAC_W-1:0] s1_frac_q;
  logic [DW-1:0]     s1_diff_q;
  logic [DW-1:0]     diff_d;

  always_comb begin
    diff_d = {2'b00, in_fp.ex} - {{(DW-K_W){1'b0}}, k_shift};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_vld_q <= 1'b0;
    else        s1_vld_q <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      s1_sop_q  <= in_sop;
      s1_sgn_q  <= in_fp.sgn;
      s1_zero_q <= (in_fp.ex == '0);
      s1_frac_q <= in_fp.frac;
      s1_diff_q <= diff_d;
    end
  end

  // stage 2: underflow flush
  fp_t  s2_fp_d;
  logic under_d;

  always_comb begin
    under_d      = s1_zero_q || s1_diff_q[DW-1] || (s1_diff_q == '0);
    s2_fp_d.sgn  = s1_sgn_q;
    s2_fp_d.frac = s1_frac_q;
    s2_fp_d.ex   = under_d ? '0 : s1_diff_q[EXP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= s1_vld_q;
  end

  always_ff @(posedge clk) begin
    if (s1_vld_q) begin
      out_sop <= s1_sop_q;
      out_fp  <= s2_fp_d;
    end
  end
endmodule

// File: rtl/scl_round_int.sv
module scl_round_int
  import scl_pkg::*;
#(
  parameter int INT_W = 24,
  parameter int DEPTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_sop,
  input  fp_t              in_fp,
  output logic             out_vld,
  output logic             out_sop,
  output logic             out_neg,
  output logic [INT_W-1:0] out_mag
);
  localparam int PW = INT_W + 2;

  logic [MANT_W-1:0] mant;
  logic [MANT_W-1:0] half_scaled;
  logic [MANT_W-1:0] rnd_w;
  logic [INT_W-1:0]  mag_d;
  int                sh;
  int                rs;

  always_comb begin
    mant        = {1'b1, in_fp.frac};
    sh          = int'({1'b0, in_fp.ex}) - BIAS - FRAC_W;
    rs          = -sh;
    half_scaled = '0;
    rnd_w       = '0;
    mag_d       = '0;
    if (in_fp.ex == '0) begin
      mag_d = '0;
    end else if (sh >= 0) begin
      mag_d = '1;
    end else if (rs > MANT_W) begin
      mag_d = '0;
    end else begin
      // one fraction bit kept; it picks the increment
      half_scaled = mant >> (rs - 1);
      rnd_w       = (half_scaled >> 1) + {{(MANT_W-1){1'b0}}, half_scaled[0]};
      if (rnd_w[MANT_W-1:INT_W] != '0) mag_d = '1;
      else                             mag_d = rnd_w[INT_W-1:0];
    end
  end

  logic             r_vld_q, r_sop_q, r_neg_q;
  logic [INT_W-1:0] r_mag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_vld_q <= 1'b0;
    else        r_vld_q <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      r_sop_q <= in_sop;
      r_neg_q <= in_fp.sgn && (mag_d != '0);
      r_mag_q <= mag_d;
    end
  end

  logic [PW-1:0] dly_out;

  scl_pipe_dly #(.W(PW), .D(DEPTH)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (r_vld_q),
    .in_dat  ({r_sop_q, r_neg_q, r_mag_q}),
    .out_vld (out_vld),
    .out_dat (dly_out)
  );

  assign out_sop = dly_out[PW-1];
  assign out_neg = dly_out[PW-2];
  assign out_mag = dly_out[INT_W-1:0];
endmodule

// File: rtl/scl_carry_acc.sv
module scl_carry_acc
  import scl_pkg::*;
#(
  parameter int INT_W   = 24,
  parameter int CARRY_W = INT_W - 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_sop,
  input  logic               in_neg,
  input  logic [INT_W-1:0]   in_mag,
  output logic               dig_vld,
  output logic [DIG_W-1:0]   dig,
  output logic [CARRY_W-1:0] carry_q
);
  localparam int SW = INT_W + 1;

  logic [CARRY_W-1:0] cin;
  logic [INT_W-1:0]   addend;
  logic [SW-1:0]      sum;
  logic [CARRY_W-1:0] carry_d;
  logic [DIG_W-1:0]   dig_d;

  always_comb begin
    cin     = in_sop ? '0 : carry_q;
    addend  = in_neg ? '0 : in_mag;
    sum     = {1'b0, addend} + {{(SW-CARRY_W){1'b0}}, cin};
    dig_d   = sum[DIG_W-1:0];
    carry_d = sum[SW-1:DIG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_vld <= 1'b0;
      dig     <= '0;
      carry_q <= '0;
    end else begin
      dig_vld <= in_vld;
      if (in_vld) begin
        dig     <= dig_d;
        carry_q <= carry_d;
      end
    end
  end
endmodule

// File: rtl/scl_digit_emit.sv
module scl_digit_emit
  import scl_pkg::*;
#(
  parameter int K_W     = 4,
  parameter int INT_W   = 24,
  parameter int SCL_LAT = 2,
  parameter int RC_LAT  = 10,
  localparam int CARRY_W = INT_W - 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic [FP_W-1:0]    in_val,
  input  logic [K_W-1:0]     k_shift,
  output logic               digit_valid,
  output logic [DIG_W-1:0]   digit,
  output logic [CARRY_W-1:0] carry_out
);
  localparam int RND_DLY = RC_LAT - 2;
  localparam int SCL_DLY = SCL_LAT - 2;

  logic rst_n_s;

  scl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  logic sc_vld, sc_sop;
  fp_t  sc_fp;

  scl_exp_scaler #(.K_W(K_W)) u_scale (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .in_vld  (in_valid),
    .in_sop  (in_sop),
    .in_fp   (fp_t'(in_val)),
    .k_shift (k_shift),
    .out_vld (sc_vld),
    .out_sop (sc_sop),
    .out_fp  (sc_fp)
  );

  logic          sx_vld;
  logic [FP_W:0] sx_dat;

  scl_pipe_dly #(.W(FP_W + 1), .D(SCL_DLY)) u_scl_pad (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .in_vld  (sc_vld),
    .in_dat  ({sc_sop, sc_fp}),
    .out_vld (sx_vld),
    .out_dat (sx_dat)
  );

  logic             rn_vld, rn_sop, rn_neg;
  logic [INT_W-1:0] rn_mag;

  scl_round_int #(.INT_W(INT_W), .DEPTH(RND_DLY)) u_round (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .in_vld  (sx_vld),
    .in_sop  (sx_dat[FP_W]),
    .in_fp   (fp_t'(sx_dat[FP_W-1:0])),
    .out_vld (rn_vld),
    .out_sop (rn_sop),
    .out_neg (rn_neg),
    .out_mag (rn_mag)
  );

  scl_carry_acc #(.INT_W(INT_W), .CARRY_W(CARRY_W)) u_carry (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .in_vld  (rn_vld),
    .in_sop  (rn_sop),
    .in_neg  (rn_neg),
    .in_mag  (rn_mag),
    .dig_vld (digit_valid),
    .dig     (digit),
    .carry_q (carry_out)
  );
endmodule

// File: rtl/scl_digit_emit_chk.sv
module scl_digit_emit_chk #(
  parameter int FP_W    = 35,
  parameter int LAT     = 12,
  parameter int CARRY_W = 21
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_sop,
  input logic [FP_W-1:0]    in_val,
  input logic               digit_valid,
  input logic [3:0]         digit,
  input logic [CARRY_W-1:0] carry_out
);
  localparam int FRAC_W = 27;

  logic [LAT-1:0] vld_sr, zsop_sr, nsop_sr;
  logic zsop_in, nsop_in;

  assign zsop_in = in_valid && in_sop && (in_val[FP_W-2:FRAC_W] == '0);
  assign nsop_in = in_valid && in_sop && in_val[FP_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sr  <= '0;
      zsop_sr <= '0;
      nsop_sr <= '0;
    end else begin
      vld_sr  <= {vld_sr[LAT-2:0], in_valid};
      zsop_sr <= {zsop_sr[LAT-2:0], zsop_in};
      nsop_sr <= {nsop_sr[LAT-2:0], nsop_in};
    end
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!digit_valid && carry_out == '0);
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    digit_valid == vld_sr[LAT-1]);

  assert_carry_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !digit_valid |-> $stable(carry_out));

  assert_sop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zsop_sr[LAT-1] |-> (digit == 4'd0 && carry_out == '0));

  assert_neg_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nsop_sr[LAT-1] |-> (digit == 4'd0 && carry_out == '0));
endmodule

bind scl_digit_emit scl_digit_emit_chk #(
  .FP_W    (35),
  .LAT     (SCL_LAT + RC_LAT),
  .CARRY_W (CARRY_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_sop      (in_sop),
  .in_val      (in_val),
  .digit_valid (digit_valid),
  .digit       (digit),
  .carry_out   (carry_out)
);

// File: tb/scl_digit_emit_bench.sv
module scl_digit_emit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [34:0] in_val = '0;
  logic [3:0]  k_shift = '0;
  logic        digit_valid;
  logic [3:0]  digit;
  logic [20:0] carry_out;

  always #2 clk = ~clk;

  scl_digit_emit u_scl_digit_emit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_val(in_val), .k_shift(k_shift), .digit_valid(digit_valid),
    .digit(digit), .carry_out(carry_out)
  );

  typedef struct {
    int     dig;
    int     car;
    longint t;
    string  req;
  } exp_t;

  exp_t   q[$];
  int     checks = 0;
  int     failures = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [34:0] enc(real x);
    real    ax;
    int     e;
    longint f;
    logic   s;
    if (x == 0.0) return '0;
    s  = (x < 0.0);
    ax = s ? -x : x;
    e  = 0;
    while (ax >= 2.0) begin ax = ax / 2.0; e++; end
    while (ax < 1.0)  begin ax = ax * 2.0; e--; end
    f = longint'($rtoi((ax - 1.0) * 134217728.0 + 0.5));
    if (f >= 134217728) begin f = 0; e++; end
    return {s, 7'(e + 63), 27'(f)};
  endfunction

  // driver: one coefficient per call, expectation pushed to scoreboard
  task automatic drive(logic [34:0] v, int kk, bit sop, int ed, int ec, string req);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1;
    in_sop   = sop;
    in_val   = v;
    k_shift  = 4'(kk);
    it.dig = ed; it.car = ec; it.t = cyc; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    idle(2);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && digit_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", "unexpected digit", digit, -1);
      end else begin
        exp_t it;
        it = q.pop_front();
        check(cyc - it.t == 12, "R2", "latency", cyc - it.t, 12);
        check(digit == 4'(it.dig), it.req, "digit", digit, it.dig);
        check(carry_out == 21'(it.car), it.req, "carry", carry_out, it.car);
      end
    end
  end

  // convolution scenario: exact product digits from 64-bit arithmetic
  task automatic conv_run(logic [31:0] a, logic [31:0] b, int pert, bit bubble);
    longint unsigned prod;
    int carry;
    prod  = longint'(a) * longint'(b);
    carry = 0;
    for (int j = 0; j < 16; j++) begin
      int  c;
      real x;
      c = 0;
      for (int i = 0; i < 8; i++)
        if (j - i >= 0 && j - i < 8)
          c += int'(a[4*i +: 4]) * int'(b[4*(j-i) +: 4]);
      x = (real'(c) + 0.1 * real'(((j * 7 + pert) % 9) - 4)) * 16.0;
      carry = (c + carry) / 16;
      drive(enc(x), 4, j == 0, int'(prod[4*j +: 4]), carry, "R9");
      if (bubble && j == 5) idle(3);
    end
    idle(1);
    drain();
    check(carry_out == 0, "R9", "final carry", carry_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(digit_valid == 1'b0, "R1", "valid in reset", digit_valid, 0);
    check(carry_out == 0, "R1", "carry in reset", carry_out, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(digit_valid == 1'b0, "R1", "valid after reset", digit_valid, 0);
    check(carry_out == 0, "R1", "carry after reset", carry_out, 0);

    // rounding, digit/carry split, k = 3
    drive(enc(37.4 * 8.0), 3, 1, 5, 2, "R4");
    drive(enc(0.6 * 8.0), 3, 0, 3, 0, "R4");
    drive(enc(15.49 * 8.0), 3, 0, 15, 0, "R4");
    drive(enc(16.51 * 8.0), 3, 0, 1, 1, "R5");
    drive(enc(-0.4 * 8.0), 3, 0, 1, 0, "R7");
    drive(enc(-5.0 * 8.0), 3, 1, 0, 0, "R7");
    drive(enc(40.0 * 8.0), 3, 0, 8, 2, "R5");
    drive(enc(3.0 * 8.0), 3, 1, 3, 0, "R6");
    // scaling variants
    drive(enc(200.2), 0, 1, 8, 12, "R3");
    drive('0, 0, 0, 12, 0, "R3");
    drive(enc(2.0 ** -60), 5, 1, 0, 0, "R3");
    drive(enc(7.3 * 32768.0), 15, 1, 7, 0, "R3");
    drive(enc(1000.0 * 1024.0), 10, 1, 8, 62, "R5");
    idle(1);
    drain();

    // idle cycles keep the carry
    drive(enc(33.0 * 4.0), 2, 1, 1, 2, "R8");
    idle(1);
    drain();
    idle(5);
    check(carry_out == 2, "R8", "carry held over idle", carry_out, 2);
    drive(enc(0.2 * 4.0), 2, 0, 2, 0, "R8");
    idle(1);
    drain();

    conv_run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0);
    conv_run(32'h1234_5678, 32'h9ABC_DEF0, 3, 1'b1);
    conv_run(32'h0000_0000, 32'hABCD_EF01, 5, 1'b0);
    conv_run(32'h8000_0001, 32'h7FFF_FFFF, 8, 1'b1);

    check(q.size() == 0, "R2", "pending digits", q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule